// File: doc/BRIEF.md
# Three-Wire Configuration Port for a Clock Synthesizer

This block is the receive side of a programming port that a host uses to configure a clock-synthesizer core. The host drives three wires: a serial data line, a serial clock, and a load strobe. Every rising edge of the serial clock shifts one bit into a 24-bit word, most significant bit first. The shift register keeps taking bits for as long as the host clocks it. While the strobe stays low, none of those bits reach the parallel outputs.

When the strobe rises, the two bits that entered last, which are the word's least significant bits, choose a destination. That destination latch then takes its field from the word. Three latches exist: a 14-bit reference-divide count, a 13-bit feedback-divide count and a 22-bit function/control word. Each latch drives parallel outputs. Each write also raises a one-cycle pulse for that latch, so the divider it feeds can reload.

All three wires are brought into the system clock domain through two-flop synchronizers, and their edges are detected there. Reset clears the reference and function latches. The feedback latch resets to 1, so the divider it feeds never starts with a count of zero.

Top module: `cfg_serial_port`

## Requirements
- R1: After reset the reference count reads 0, the function word reads 0, the feedback count reads 1 and no update pulse is high.
- R2: Each rising edge of the serial clock shifts one bit in, most significant bit first. When the strobe rises with control bits [1:0] = 00, the reference latch takes word bits [15:2], and word bits [23:16] are ignored.
- R3: Control code 01 loads word bits [14:2] into the feedback latch, and bits [23:15] are ignored. The smallest count, 1, is accepted like any other value.
- R4: Control code 10 loads word bits [23:2] into the function latch.
- R5: A strobe with control code 11 changes no latch and raises no update pulse.
- R6: A write leaves the two latches it does not address unchanged.
- R7: Shifting a complete word without raising the strobe changes no output.
- R8: Each strobe that addresses a latch raises exactly that latch's update pulse for exactly one system clock cycle. The pulse comes in the same cycle as the new latch value, and no two pulses are ever high together.
- R9: If more than 24 bits are shifted before the strobe, only the last 24 bits count.
- R10: The host keeps these serial timing minimums: data is stable 10 ns before and 10 ns after each rising serial clock edge, each serial clock phase lasts at least 25 ns, the strobe rises at least 10 ns after the last serial clock edge, and the strobe pulse lasts at least 20 ns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_data_i | input | 1 | Serial data line |
| ser_clk_i | input | 1 | Serial clock; data is taken on its rising edge |
| ser_load_i | input | 1 | Load strobe; its rising edge commits the word |
| ref_div_o | output | 14 | Reference-divide count latch |
| fb_div_o | output | 13 | Feedback-divide count latch |
| func_o | output | 22 | Function/control latch |
| ref_upd_o | output | 1 | One-cycle pulse on a reference latch write |
| fb_upd_o | output | 1 | One-cycle pulse on a feedback latch write |
| func_upd_o | output | 1 | One-cycle pulse on a function latch write |

## Verification
Some properties are checked in every cycle. The update pulses are never high together and each lasts one cycle. A latch can change only in a cycle when its own pulse is high. Every pulse is preceded by a detected strobe edge.

Other behaviour only shows up in the bench's scenarios:
- which field of the word lands in which latch
- the MSB-first order and the discarding of bits beyond 24
- that code 11 and a shift with no strobe do nothing
- the reset values
- that the host waveforms meet the serial timing minimums

// File: rtl/cfg_port_pkg.sv
`timescale 1ns/1ps
package cfg_port_pkg;

    // Destination selected by the two least significant bits of the word.
    typedef enum logic [1:0] {
        DST_REF  = 2'b00,
        DST_FB   = 2'b01,
        DST_FUNC = 2'b10,
        DST_NONE = 2'b11
    } dest_e;

    localparam int CTRL_W = 2;

endpackage

// File: rtl/cfg_sync.sv
`timescale 1ns/1ps
module cfg_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [STAGES-1:0] chain_d [W];
    logic [STAGES-1:0] chain_q [W];

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_comb begin
            chain_d[i] = {chain_q[i][STAGES-2:0], async_i[i]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q[i] <= '0;
            end else begin
                chain_q[i] <= chain_d[i];
            end
        end

        assign sync_o[i] = chain_q[i][STAGES-1];
    end

endmodule

// File: rtl/cfg_shift.sv
`timescale 1ns/1ps
module cfg_shift #(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              sdata_s,
    output logic [WORD_W-1:0] word_o
);

    typedef struct packed {
        logic              clk_prev;
        logic [WORD_W-1:0] word;
    } shift_t;

    shift_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.clk_prev = sclk_s;
        if (sclk_s && !st_q.clk_prev) begin
            st_d.word = {st_q.word[WORD_W-2:0], sdata_s};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_o = st_q.word;

endmodule

// File: rtl/cfg_latch_bank.sv
`timescale 1ns/1ps
module cfg_latch_bank
    import cfg_port_pkg::*;
#(
    parameter int WORD_W = 24,
    parameter int REF_W  = 14,
    parameter int FB_W   = 13,
    localparam int FUNC_W = WORD_W - CTRL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_rise,
    input  logic [WORD_W-1:0] word_i,
    output logic [REF_W-1:0]  ref_div_o,
    output logic [FB_W-1:0]   fb_div_o,
    output logic [FUNC_W-1:0] func_o,
    output logic              ref_upd_o,
    output logic              fb_upd_o,
    output logic              func_upd_o
);

    typedef struct packed {
        logic [REF_W-1:0]  ref_div;
        logic [FB_W-1:0]   fb_div;
        logic [FUNC_W-1:0] func;
        logic              ref_upd;
        logic              fb_upd;
        logic              func_upd;
    } bank_t;

    bank_t bk_d, bk_q;
    dest_e dest;

    assign dest = dest_e'(word_i[CTRL_W-1:0]);

    always_comb begin
        bk_d          = bk_q;
        bk_d.ref_upd  = 1'b0;
        bk_d.fb_upd   = 1'b0;
        bk_d.func_upd = 1'b0;
        if (ld_rise) begin
            unique case (dest)
                DST_REF: begin
                    bk_d.ref_div = word_i[CTRL_W +: REF_W];
                    bk_d.ref_upd = 1'b1;
                end
                DST_FB: begin
                    bk_d.fb_div = word_i[CTRL_W +: FB_W];
                    bk_d.fb_upd = 1'b1;
                end
                DST_FUNC: begin
                    bk_d.func     = word_i[CTRL_W +: FUNC_W];
                    bk_d.func_upd = 1'b1;
                end
                DST_NONE: begin
                    bk_d = bk_d;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bk_q        <= '0;
            bk_q.fb_div <= FB_W'(1);
        end else begin
            bk_q <= bk_d;
        end
    end

    assign ref_div_o  = bk_q.ref_div;
    assign fb_div_o   = bk_q.fb_div;
    assign func_o     = bk_q.func;
    assign ref_upd_o  = bk_q.ref_upd;
    assign fb_upd_o   = bk_q.fb_upd;
    assign func_upd_o = bk_q.func_upd;

endmodule

// File: rtl/cfg_serial_port.sv
`timescale 1ns/1ps
module cfg_serial_port
    import cfg_port_pkg::*;
#(
    parameter int WORD_W      = 24,
    parameter int REF_W       = 14,
    parameter int FB_W        = 13,
    parameter int SYNC_STAGES = 2,
    localparam int FUNC_W     = WORD_W - CTRL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_data_i,
    input  logic              ser_clk_i,
    input  logic              ser_load_i,
    output logic [REF_W-1:0]  ref_div_o,
    output logic [FB_W-1:0]   fb_div_o,
    output logic [FUNC_W-1:0] func_o,
    output logic              ref_upd_o,
    output logic              fb_upd_o,
    output logic              func_upd_o
);

    localparam int PINS = 3;

    logic [PINS-1:0]   pins_s;
    logic              sdata_s;
    logic              sclk_s;
    logic              ld_s;
    logic [WORD_W-1:0] word;
    logic              ld_rise;

    typedef struct packed {
        logic ld_prev;
    } edge_t;

    edge_t eg_d, eg_q;

    cfg_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ser_load_i, ser_clk_i, ser_data_i}),
        .sync_o  (pins_s)
    );

    assign sdata_s = pins_s[0];
    assign sclk_s  = pins_s[1];
    assign ld_s    = pins_s[2];

    cfg_shift #(.WORD_W(WORD_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_s  (sclk_s),
        .sdata_s (sdata_s),
        .word_o  (word)
    );

    always_comb begin
        eg_d         = eg_q;
        eg_d.ld_prev = ld_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eg_q <= '0;
        end else begin
            eg_q <= eg_d;
        end
    end

    assign ld_rise = ld_s & ~eg_q.ld_prev;

    cfg_latch_bank #(.WORD_W(WORD_W), .REF_W(REF_W), .FB_W(FB_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_rise    (ld_rise),
        .word_i     (word),
        .ref_div_o  (ref_div_o),
        .fb_div_o   (fb_div_o),
        .func_o     (func_o),
        .ref_upd_o  (ref_upd_o),
        .fb_upd_o   (fb_upd_o),
        .func_upd_o (func_upd_o)
    );

endmodule

// File: rtl/cfg_serial_port_chk.sv
`timescale 1ns/1ps
module cfg_serial_port_chk #(
    parameter int REF_W  = 14,
    parameter int FB_W   = 13,
    parameter int FUNC_W = 22
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ld_rise,
    input logic [REF_W-1:0]  ref_div_o,
    input logic [FB_W-1:0]   fb_div_o,
    input logic [FUNC_W-1:0] func_o,
    input logic              ref_upd_o,
    input logic              fb_upd_o,
    input logic              func_upd_o
);

    assert_pulse_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ref_upd_o, fb_upd_o, func_upd_o}));

    assert_ref_pulse_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ref_upd_o |=> !ref_upd_o);

    assert_fb_pulse_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fb_upd_o |=> !fb_upd_o);

    assert_func_pulse_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        func_upd_o |=> !func_upd_o);

    assert_ref_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_upd_o |-> $stable(ref_div_o));

    assert_fb_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !fb_upd_o |-> $stable(fb_div_o));

    assert_func_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !func_upd_o |-> $stable(func_o));

    assert_pulse_needs_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_upd_o || fb_upd_o || func_upd_o) |-> $past(ld_rise));

endmodule

bind cfg_serial_port cfg_serial_port_chk #(
    .REF_W  (REF_W),
    .FB_W   (FB_W),
    .FUNC_W (FUNC_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld_rise    (ld_rise),
    .ref_div_o  (ref_div_o),
    .fb_div_o   (fb_div_o),
    .func_o     (func_o),
    .ref_upd_o  (ref_upd_o),
    .fb_upd_o   (fb_upd_o),
    .func_upd_o (func_upd_o)
);

// File: tb/tb_cfg_serial_port.sv
`timescale 1ns/1ps
module tb_cfg_serial_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_data = 1'b0;
    logic        ser_clk = 1'b0;
    logic        ser_load = 1'b0;
    logic [13:0] ref_div;
    logic [12:0] fb_div;
    logic [21:0] func;
    logic        ref_upd, fb_upd, func_upd;

    int n_chk = 0;
    int n_bad = 0;
    int cnt_ref = 0, cnt_fb = 0, cnt_func = 0;
    int tviol = 0;

    always #5 clk = ~clk;

    cfg_serial_port dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_data_i (ser_data),
        .ser_clk_i  (ser_clk),
        .ser_load_i (ser_load),
        .ref_div_o  (ref_div),
        .fb_div_o   (fb_div),
        .func_o     (func),
        .ref_upd_o  (ref_upd),
        .fb_upd_o   (fb_upd),
        .func_upd_o (func_upd)
    );

    // Pulse counters, sampled away from the active edge (R8)
    always @(negedge clk) begin
        if (rst_n) begin
            cnt_ref  <= cnt_ref  + int'(ref_upd);
            cnt_fb   <= cnt_fb   + int'(fb_upd);
            cnt_func <= cnt_func + int'(func_upd);
        end
    end

    // Host timing monitor (R10)
    realtime t_data = -1000.0, t_rise = -1000.0, t_fall = -1000.0;
    realtime t_edge = -1000.0, t_ld = -1000.0;

    always @(ser_data) begin
        if ($realtime - t_rise < 10.0) tviol++;
        t_data = $realtime;
    end
    always @(posedge ser_clk) begin
        if ($realtime - t_data < 10.0) tviol++;
        if ($realtime - t_fall < 25.0) tviol++;
        t_rise = $realtime;
        t_edge = $realtime;
    end
    always @(negedge ser_clk) begin
        if ($realtime - t_rise < 25.0) tviol++;
        t_fall = $realtime;
        t_edge = $realtime;
    end
    always @(posedge ser_load) begin
        if ($realtime - t_edge < 10.0) tviol++;
        t_ld = $realtime;
    end
    always @(negedge ser_load) begin
        if ($realtime - t_ld < 20.0) tviol++;
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic shift_bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk);
            ser_data = v[i];
            repeat (4) @(negedge clk);
            ser_clk = 1'b1;
            repeat (4) @(negedge clk);
            ser_clk = 1'b0;
        end
    endtask

    task automatic strobe();
        repeat (3) @(negedge clk);
        ser_load = 1'b1;
        repeat (4) @(negedge clk);
        ser_load = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    typedef struct packed {
        logic [23:0] word;
        logic [13:0] e_ref;
        logic [12:0] e_fb;
        logic [21:0] e_func;
        logic [2:0]  e_pulse;   // {ref, fb, func}
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{24'h0048D0, 14'h1234, 13'h0001, 22'h000000, 3'b100}, // R2
        '{24'h007FFD, 14'h1234, 13'h1FFF, 22'h000000, 3'b010}, // R3 R6
        '{24'hAAAAAA, 14'h1234, 13'h1FFF, 22'h2AAAAA, 3'b001}, // R4
        '{24'hFFFFFF, 14'h1234, 13'h1FFF, 22'h2AAAAA, 3'b000}, // R5
        '{24'h000005, 14'h1234, 13'h0001, 22'h2AAAAA, 3'b010}, // R3 count of 1
        '{24'hFFFFFC, 14'h3FFF, 13'h0001, 22'h2AAAAA, 3'b100}, // R2 high bits ignored
        '{24'h00AAF1, 14'h3FFF, 13'h0ABC, 22'h2AAAAA, 3'b010}, // R3 bit 15 ignored
        '{24'h555556, 14'h3FFF, 13'h0ABC, 22'h155555, 3'b001}  // R4 R6
    };

    task automatic check_state(input string req, input logic [13:0] r,
                               input logic [12:0] f, input logic [21:0] fn);
        check(req, "ref_div", 32'(ref_div), 32'(r));
        check(req, "fb_div",  32'(fb_div),  32'(f));
        check(req, "func",    32'(func),    32'(fn));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int pr, pf, pfn;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        check_state("R1", 14'h0, 13'h1, 22'h0);
        check("R1", "pulses", 32'({ref_upd, fb_upd, func_upd}), 32'h0);

        // Vector table: R2 R3 R4 R5 R6 R8
        for (int k = 0; k < NV; k++) begin
            pr = cnt_ref; pf = cnt_fb; pfn = cnt_func;
            shift_bits(32'(VEC[k].word), 24);
            strobe();
            check_state($sformatf("R2-vec%0d", k), VEC[k].e_ref, VEC[k].e_fb, VEC[k].e_func);
            check("R8", $sformatf("pulse count vec%0d", k),
                  32'({cnt_ref - pr == 1, cnt_fb - pf == 1, cnt_func - pfn == 1}),
                  32'(VEC[k].e_pulse));
            check("R8", $sformatf("pulse total vec%0d", k),
                  32'((cnt_ref - pr) + (cnt_fb - pf) + (cnt_func - pfn)),
                  32'($countones(VEC[k].e_pulse)));
        end

        // R7: full word shifted without a strobe changes nothing
        pr = cnt_ref;
        shift_bits(32'h000000, 24);
        repeat (10) @(negedge clk);
        check_state("R7", 14'h3FFF, 13'h0ABC, 22'h155555);
        check("R7", "no pulse", 32'(cnt_ref - pr), 32'h0);

        // R9: 28 bits shifted, only the last 24 count (fb count 4)
        shift_bits(32'h0F000011, 28);
        strobe();
        check_state("R9", 14'h3FFF, 13'h0004, 22'h155555);

        // R1: reset mid-operation restores reset values
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_state("R1", 14'h0, 13'h1, 22'h0);

        // R10: host waveforms respected the serial timing minimums
        check("R10", "timing violations", 32'(tviol), 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule